// File: doc/BRIEF.md
# Serial EEPROM Fill-All Command Slave

This block is the device side of a three-wire serial memory link with a chip select, a serial clock, a serial data input and a serial data output. While chip select is high it shifts in a frame that opens with a start bit. The frame it acts on is the fill-all command, which loads one 16-bit word into every location of a small on-chip word array. The frame only goes into a staging register as it arrives. The array changes on the chip-select falling edge that closes the frame, and only if that frame received exactly the number of serial clocks the command needs.

A write-enable flag gates the fill. Two short control frames set and clear the flag. After an accepted fill, a cycle counter on the system clock stands in for the programming time. A host that raises chip select again during this time sees busy (low) on the data output, and later ready (high). Dropping chip select once the counter has expired puts the output back into high impedance.

A debug read port exposes any word of the array, so a test can observe the array contents.

Top module: `uw_wral_slave`

## Requirements
- R1: After reset every word of the array holds INIT (all ones by default), the write-enable flag is clear and the data output is not driven (`do_oe` = 0).
- R2: The serial input is sampled on rising serial-clock edges while chip select is high. Zeros before the first 1 are skipped. That 1 is the start bit. A fill frame is the start bit, then opcode 00, then AW address bits whose two most significant bits are 01, then 16 data bits with the most significant bit first. Counting the start bit, it is AW+19 clocks (25 when AW = 6).
- R3: The address bits below the leading 01 of a fill frame are ignored. Every value produces the same result.
- R4: An accepted fill writes the received word to every array location and replaces the old contents directly, with no prior erase.
- R5: The array keeps its old contents after the last data clock for as long as chip select stays high. It changes only after chip select falls.
- R6: A frame that received more or fewer serial clocks than its command length before chip select fell is discarded, and the array is left unchanged.
- R7: The write-enable flag is set by the frame 1, 00, 11 followed by AW-2 don't-care bits, and cleared by 1, 00, 00 followed by AW-2 don't-care bits (AW+3 clocks each). A fill received while the flag is clear leaves the array unchanged.
- R8: The data output is not driven while a frame is being shifted in, or while chip select is low outside the status phase.
- R9: After an accepted fill, raising chip select drives the data output low while the BUSY_CYCLES system-clock timer runs, and high once it has expired. When chip select falls after the timer has expired, the output returns to high impedance.
- R10: Any frame received from the start of a fill until the status phase ends has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high, asynchronous to clk |
| sk | input | 1 | Serial clock, asynchronous to clk |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value (0 busy, 1 ready) |
| do_oe | output | 1 | Drive enable for the data output; 0 means high impedance |
| dbg_addr | input | $clog2(DEPTH) | Debug read address |
| dbg_data | output | DW | Array word at dbg_addr |

## Verification
The assertions assume that the serial clock and chip select stay at each level for several system clocks. Under that assumption every serial-clock rise and every chip-select fall survives the synchronizer as exactly one edge. They also assume that chip select stays low for at least two synchronized cycles when it closes a frame. The bench changes `sk`, `di` and `cs` only on falling system-clock edges, holds each level for four system clocks and waits eight clocks after every frame, so the stimulus stays inside these limits. It also sets the busy time longer than one full frame, so that a second frame really does arrive while the block is busy.

// File: rtl/uw_pkg.sv
package uw_pkg;
    localparam int DATA_W = 16;

    // opcode shared by fill and enable/disable frames
    localparam logic [1:0] OPC_CTRL = 2'b00;
    // top two address bits select the control function
    localparam logic [1:0] SEL_FILL = 2'b01;
    localparam logic [1:0] SEL_WEN  = 2'b11;
    localparam logic [1:0] SEL_WDIS = 2'b00;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_FILL = 2'd1,
        CMD_WEN  = 2'd2,
        CMD_WDIS = 2'd3
    } uw_cmd_e;
endpackage

// File: rtl/uw_sync_edge.sv
module uw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise,
    output logic cs_fall
);
    typedef struct packed {
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] sk;
        logic [STAGES-1:0] di;
        logic              sk_last;
        logic              cs_last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.cs      = {st_q.cs[STAGES-2:0], cs};
        st_d.sk      = {st_q.sk[STAGES-2:0], sk};
        st_d.di      = {st_q.di[STAGES-2:0], di};
        st_d.sk_last = st_q.sk[STAGES-1];
        st_d.cs_last = st_q.cs[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cs_s    = st_q.cs[STAGES-1];
    assign di_s    = st_q.di[STAGES-1];
    assign sk_rise = st_q.sk[STAGES-1] & ~st_q.sk_last;
    assign cs_fall = ~st_q.cs[STAGES-1] & st_q.cs_last;
endmodule

// File: rtl/uw_cmd_rx.sv
module uw_cmd_rx
    import uw_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          di_s,
    input  logic          sk_rise,
    input  logic          cs_fall,
    input  logic          hold,
    output uw_cmd_e       cmd,
    output logic [DW-1:0] cmd_data,
    output logic          shifting
);
    localparam int FRAME_W  = 2 + AW + DW;
    localparam int LEN_FILL = 1 + FRAME_W;
    localparam int LEN_CTL  = 3 + AW;
    localparam int CNT_MAX  = LEN_FILL + 1;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic               started;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sreg;
        uw_cmd_e            cmd;
        logic [DW-1:0]      data;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d     = rx_q;
        rx_d.cmd = CMD_NONE;
        if (cs_fall) begin
            if (rx_q.started && !hold) begin
                if (rx_q.cnt == CNT_W'(LEN_FILL) &&
                    rx_q.sreg[FRAME_W-1 -: 4] == {OPC_CTRL, SEL_FILL}) begin
                    rx_d.cmd  = CMD_FILL;
                    rx_d.data = rx_q.sreg[DW-1:0];
                end else if (rx_q.cnt == CNT_W'(LEN_CTL)) begin
                    if (rx_q.sreg[AW+1 -: 4] == {OPC_CTRL, SEL_WEN})
                        rx_d.cmd = CMD_WEN;
                    else if (rx_q.sreg[AW+1 -: 4] == {OPC_CTRL, SEL_WDIS})
                        rx_d.cmd = CMD_WDIS;
                end
            end
            rx_d.started = 1'b0;
            rx_d.cnt     = '0;
            rx_d.sreg    = '0;
        end else if (!cs_s || hold) begin
            rx_d.started = 1'b0;
            rx_d.cnt     = '0;
            rx_d.sreg    = '0;
        end else if (sk_rise) begin
            if (!rx_q.started) begin
                if (di_s) begin
                    rx_d.started = 1'b1;
                    rx_d.cnt     = CNT_W'(1);
                end
            end else begin
                if (rx_q.cnt != CNT_W'(CNT_MAX))
                    rx_d.cnt = rx_q.cnt + 1'b1;
                rx_d.sreg = {rx_q.sreg[FRAME_W-2:0], di_s};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q.started <= 1'b0;
            rx_q.cnt     <= '0;
            rx_q.sreg    <= '0;
            rx_q.cmd     <= CMD_NONE;
            rx_q.data    <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign cmd      = rx_q.cmd;
    assign cmd_data = rx_q.data;
    assign shifting = rx_q.started;
endmodule

// File: rtl/uw_mem_array.sv
module uw_mem_array #(
    parameter int          DW    = 16,
    parameter int          DEPTH = 16,
    parameter logic [DW-1:0] INIT = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_all,
    input  logic [DW-1:0]              wdata,
    output logic [DEPTH-1:0][DW-1:0]   words
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [DW-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (we_all) w_d = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) w_q <= INIT;
            else        w_q <= w_d;
        end

        assign words[i] = w_q;
    end
endmodule

// File: rtl/uw_wral_slave.sv
module uw_wral_slave
    import uw_pkg::*;
#(
    parameter int            AW          = 6,
    parameter int            DW          = DATA_W,
    parameter int            DEPTH       = 16,
    parameter int            BUSY_CYCLES = 64,
    parameter int            SYNC_STAGES = 2,
    parameter logic [DW-1:0] INIT        = '1,
    localparam int           DBG_AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    output logic              do_o,
    output logic              do_oe,
    input  logic [DBG_AW-1:0] dbg_addr,
    output logic [DW-1:0]     dbg_data
);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic              wel;
        logic              busy;
        logic [BUSY_W-1:0] timer;
        logic              status;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                     cs_s, di_s, sk_rise, cs_fall;
    uw_cmd_e                  cmd;
    logic [DW-1:0]            cmd_data;
    logic                     shifting;
    logic                     we_all;
    logic [DEPTH-1:0][DW-1:0] mem_words;
    logic                     wel_q, busy_q, status_q;

    uw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .cs_s    (cs_s),
        .di_s    (di_s),
        .sk_rise (sk_rise),
        .cs_fall (cs_fall)
    );

    uw_cmd_rx #(.AW(AW), .DW(DW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (cs_s),
        .di_s     (di_s),
        .sk_rise  (sk_rise),
        .cs_fall  (cs_fall),
        .hold     (ctl_q.status),
        .cmd      (cmd),
        .cmd_data (cmd_data),
        .shifting (shifting)
    );

    uw_mem_array #(.DW(DW), .DEPTH(DEPTH), .INIT(INIT)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_all (we_all),
        .wdata  (cmd_data),
        .words  (mem_words)
    );

    always_comb begin
        ctl_d  = ctl_q;
        we_all = 1'b0;
        if (ctl_q.busy) begin
            if (ctl_q.timer <= BUSY_W'(1)) begin
                ctl_d.busy  = 1'b0;
                ctl_d.timer = '0;
            end else begin
                ctl_d.timer = ctl_q.timer - 1'b1;
            end
        end
        if (ctl_q.status && !ctl_q.busy && !cs_s)
            ctl_d.status = 1'b0;
        if (!ctl_q.status) begin
            unique case (cmd)
                CMD_WEN:  ctl_d.wel = 1'b1;
                CMD_WDIS: ctl_d.wel = 1'b0;
                CMD_FILL: begin
                    if (ctl_q.wel) begin
                        we_all       = 1'b1;
                        ctl_d.busy   = 1'b1;
                        ctl_d.timer  = BUSY_W'(BUSY_CYCLES);
                        ctl_d.status = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign wel_q    = ctl_q.wel;
    assign busy_q   = ctl_q.busy;
    assign status_q = ctl_q.status;

    assign do_oe    = ctl_q.status & cs_s & ~shifting;
    assign do_o     = ~ctl_q.busy;
    assign dbg_data = mem_words[dbg_addr];
endmodule

// File: rtl/uw_wral_chk.sv
module uw_wral_chk
    import uw_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_s,
    input  uw_cmd_e                  cmd,
    input  logic                     shifting,
    input  logic                     wel_q,
    input  logic                     busy_q,
    input  logic                     status_q,
    input  logic                     do_oe,
    input  logic [DEPTH-1:0][DW-1:0] words
);
    logic all_same;

    always_comb begin
        all_same = 1'b1;
        for (int i = 1; i < DEPTH; i++)
            if (words[i] != words[0]) all_same = 1'b0;
    end

    // R4: after any change the whole array holds a single word
    a_r4_all_words_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (words != $past(words)) |-> all_same);

    // R7: the array changes only if the enable flag was set
    a_r7_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (words != $past(words)) |-> $past(wel_q, 2));

    // R10: no further change while the busy timer runs
    a_r10_no_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(words));

    // R5: a fill is decoded only right after chip select fell
    a_r5_fill_at_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_FILL) |-> (!$past(cs_s) && $past(cs_s, 2)));

    // R8: never driven while a frame is being shifted in
    a_r8_hiz_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
        shifting |-> !do_oe);

    // R9: the status phase opens with busy set
    a_r9_status_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> busy_q);
endmodule

bind uw_wral_slave uw_wral_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .cmd      (cmd),
    .shifting (shifting),
    .wel_q    (wel_q),
    .busy_q   (busy_q),
    .status_q (status_q),
    .do_oe    (do_oe),
    .words    (mem_words)
);

// File: tb/uw_wral_slave_tb.sv
module uw_wral_slave_tb;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int BUSY  = 300;
    localparam int HALF  = 4;
    localparam int NFILL = AW + 19;
    localparam int NCTL  = AW + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_o, do_oe;
    logic [3:0] dbg_addr = '0;
    logic [DW-1:0] dbg_data;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uw_wral_slave #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .do_o(do_o), .do_oe(do_oe), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        di = b; clks(HALF);
        sk = 1'b1; clks(HALF);
        sk = 1'b0;
    endtask

    // shift n bits MSB first after lz leading zeros; close the frame if drop set
    task automatic frame(input logic [31:0] bits, input int n, input int lz, input bit drop);
        cs = 1'b1; clks(HALF);
        for (int i = 0; i < lz; i++) send_bit(1'b0);
        for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
        di = 1'b0;
        if (drop) begin
            clks(HALF); cs = 1'b0; clks(8);
        end
    endtask

    function automatic logic [31:0] fill_bits(input logic [3:0] lo, input logic [15:0] d);
        return {7'd0, 1'b1, 2'b00, 2'b01, lo, d};
    endfunction

    task automatic ctl(input logic [1:0] sel, input logic [3:0] lo);
        frame({23'd0, 1'b1, 2'b00, sel, lo}, NCTL, 0, 1'b1);
    endtask

    task automatic check_all(input logic [15:0] exp, input string req);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk) dbg_addr = 4'(a);
            #1 chk({16'd0, dbg_data}, {16'd0, exp}, req);
        end
    endtask

    // poll status after an accepted fill: busy low, then ready high, then high-Z
    task automatic finish_busy();
        int waited;
        cs = 1'b1; clks(6);
        chk({31'd0, do_oe}, 32'd1, "R9 driven in status");
        chk({31'd0, do_o}, 32'd0, "R9 busy low");
        waited = 0;
        while (do_o !== 1'b1 && waited < BUSY + 50) begin
            clks(1); waited++;
        end
        chk({31'd0, do_o}, 32'd1, "R9 ready high");
        cs = 1'b0; clks(6);
        chk({31'd0, do_oe}, 32'd0, "R9 hi-Z after status");
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk); cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] exp;
        clks(5); rst_n = 1'b1; clks(3);

        // R1 reset state
        chk({31'd0, do_oe}, 32'd0, "R1 do_oe reset");
        check_all(16'hFFFF, "R1 reset contents");

        // R7 fill without enable ignored
        frame(fill_bits(4'h0, 16'h1234), NFILL, 0, 1'b1);
        check_all(16'hFFFF, "R7 no enable");
        chk({31'd0, do_oe}, 32'd0, "R8 no drive cs low");

        // R5 no change while cs stays high, then R2 and R4 fill
        ctl(2'b11, 4'h0);
        frame(fill_bits(4'h0, 16'h1234), NFILL, 0, 1'b0);
        clks(12);
        chk({31'd0, do_oe}, 32'd0, "R8 no drive during frame");
        check_all(16'hFFFF, "R5 before cs fall");
        cs = 1'b0; clks(8);
        check_all(16'h1234, "R2 R4 fill");
        finish_busy();

        // R4 overwrite without erase, R2 MSB first
        frame(fill_bits(4'h9, 16'h8003), NFILL, 0, 1'b1);
        check_all(16'h8003, "R4 R2 overwrite msb first");
        finish_busy();

        // R3 address don't care sweep, R2 leading zeros
        for (int k = 0; k < 16; k++) begin
            exp = 16'(k * 16'h1357) ^ 16'hA5A5;
            frame(fill_bits(4'(k), exp), NFILL, k % 4, 1'b1);
            check_all(exp, "R3 addr sweep");
            finish_busy();
        end
        exp = 16'(15 * 16'h1357) ^ 16'hA5A5;

        // R6 one clock too many, one too few
        frame({fill_bits(4'h0, 16'h0001), 1'b0}, NFILL + 1, 0, 1'b1);
        check_all(exp, "R6 extra clock");
        frame(fill_bits(4'h0, 16'h0002) >> 1, NFILL - 1, 0, 1'b1);
        check_all(exp, "R6 short frame");

        // R10 frame during busy ignored
        frame(fill_bits(4'h0, 16'h5555), NFILL, 0, 1'b1);
        frame(fill_bits(4'h0, 16'h0F0F), NFILL, 0, 1'b1);
        check_all(16'h5555, "R10 ignored while busy");
        finish_busy();

        // R7 disable then fill ignored
        ctl(2'b00, 4'hA);
        frame(fill_bits(4'h0, 16'h7777), NFILL, 0, 1'b1);
        check_all(16'h5555, "R7 disabled");
        chk({31'd0, do_oe}, 32'd0, "R7 no status after ignored fill");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule